// File: doc/BRIEF.md
# Banked Serial Register Access Slave

This block terminates a four-wire serial control link: an active-low select, a serial clock, a data input and a data output for reads. It turns that link into a parallel register-file port. Every transaction is a 24-bit frame. Its four leading control bits say whether the access writes or reads, whether it targets the analog bank or the digital banks, whether it selects a page or touches a register, and which of two channels is meant. A 12-bit address and an 8-bit data byte follow the control bits.

All serial pins are synchronized into the system clock domain and edge-detected, so the system clock must run at least four times faster than the serial clock. The duty cycle of the serial clock does not matter. Page accesses update one of four internal page registers, one for each bank/channel pair. Register accesses present the stored page of their bank/channel on the register-file port, alongside the address. Register writes raise a single-cycle strobe once the frame is complete. Reads fetch a byte from the register file, or from the page store for a page read, and shift it back out MSB first.

Top module: `spi_bank_slave`

## Requirements
- R1: Bits are taken only while `ser_en_n` is low, one bit on each rising edge of `ser_clk`. Clock edges seen while `ser_en_n` is high have no effect on the next frame.
- R2: A frame is sent MSB first as: bit 23 read flag (1 = read), bit 22 bank (0 = analog, 1 = digital), bit 21 target (0 = page, 1 = register), bit 20 channel (0 = A, 1 = B), bits 19..8 address, bits 7..0 data. `rf_bank`, `rf_chan` and `rf_addr` carry these fields, and `rf_wdata` carries the data byte.
- R3: A register write (read flag 0, target 1) raises `rf_wr` for exactly one system clock, after the 24th bit has been taken.
- R4: A frame deselected before its 24th bit is discarded. This includes a deselect that is synchronized in the same system clock as the 24th rising edge. A discarded frame issues no strobe and leaves the page store unchanged.
- R5: A page write (read flag 0, target 0) stores the data byte in the page register indexed by {bank, channel} and does not raise `rf_wr`.
- R6: During a register access, `rf_page` shows the page value stored for the frame's bank and channel. All page registers are zero after reset.
- R7: During a register read, `ser_dout` carries `rf_rdata`, MSB first. It changes on the falling edge that follows rising edges 16 through 23, so the master latches data bit 7-k on rising edge 17+k.
- R8: A page read (read flag 1, target 0) shifts out the stored page value of its bank and channel, with the same timing as R7.
- R9: `ser_dout` is low while deselected, during the header and address bits, and throughout write frames.
- R10: A read frame raises no `rf_wr` and leaves the page store unchanged.
- R11: Clock edges after the 24th bit of a frame are ignored: no second strobe is raised, and the data byte is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial read data out |
| rf_bank | output | 1 | Bank of the current access (1 = digital) |
| rf_chan | output | 1 | Channel of the current access (1 = B) |
| rf_page | output | DATA_W | Stored page for the current bank/channel |
| rf_addr | output | ADDR_W | Register address |
| rf_wr | output | 1 | One-cycle register write strobe |
| rf_wdata | output | DATA_W | Register write data |
| rf_rdata | input | DATA_W | Register read data for the presented address |

## Verification
Frame completion and deselection can be synchronized in the same system clock. This happens when the select rises together with the 24th clock edge. The bench provokes this by releasing `ser_en_n` at the very moment it raises the last `ser_clk` edge. It then judges that no strobe was counted, and it contrasts this with normal frames, where the select is released later and exactly one strobe appears. The bench sweeps all four bank/channel pairs over several addresses for page writes, register writes, register reads and page reads. It computes each expected readback from a register-file model that it drives itself. It also covers truncated frames, overlong frames and clock pulses while deselected.

// File: rtl/spi_bank_pkg.sv
`timescale 1ns/1ps
package spi_bank_pkg;
   localparam int HDR_W    = 4;
   localparam int PG_IDX_W = 2;
   localparam int NUM_PG   = 1 << PG_IDX_W;

   typedef struct packed {
      logic rd;       // 1 = read back
      logic digital;  // 1 = digital bank
      logic reg_acc;  // 1 = register, 0 = page
      logic chan_b;   // 1 = channel B
   } hdr_t;
endpackage

// File: rtl/spi_bank_sync.sv
`timescale 1ns/1ps
module spi_bank_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic en_n_i,
   input  logic din_i,
   output logic rise_o,
   output logic fall_o,
   output logic en_act_o,
   output logic din_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_bank_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] s_clk, s_en, s_din;
   logic              clk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_clk <= '0;
         s_en  <= '1;
         s_din <= '0;
         clk_q <= 1'b0;
      end else begin
         s_clk <= {s_clk[STAGES-2:0], sclk_i};
         s_en  <= {s_en[STAGES-2:0], en_n_i};
         s_din <= {s_din[STAGES-2:0], din_i};
         clk_q <= s_clk[STAGES-1];
      end
   end

   assign rise_o   = s_clk[STAGES-1] & ~clk_q;
   assign fall_o   = ~s_clk[STAGES-1] & clk_q;
   assign en_act_o = ~s_en[STAGES-1];
   assign din_o    = s_din[STAGES-1];

   AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_o && fall_o)); // R1
endmodule

// File: rtl/spi_bank_frame.sv
`timescale 1ns/1ps
module spi_bank_frame
   import spi_bank_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              en_act_i,
   input  logic              din_i,
   input  logic [DATA_W-1:0] rd_src_i,
   output hdr_t              hdr_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              rf_wr_o,
   output logic              pg_wr_o,
   output logic              dout_o
);
   localparam int HA_LEN    = HDR_W + ADDR_W;
   localparam int FRAME_LEN = HA_LEN + DATA_W;
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] C_HA    = CNT_W'(HA_LEN);
   localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_LEN);

   if (DATA_W > HA_LEN) begin : g_bad_width
      $error("spi_bank_frame: DATA_W must not exceed header plus address");
   end

   logic [HA_LEN-2:0] sh;
   logic [HA_LEN-1:0] sh_nxt;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] rd_sh;
   logic              load;

   assign sh_nxt = {sh, din_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         cnt     <= '0;
         hdr_o   <= '0;
         addr_o  <= '0;
         wdata_o <= '0;
         rf_wr_o <= 1'b0;
         pg_wr_o <= 1'b0;
         dout_o  <= 1'b0;
         rd_sh   <= '0;
         load    <= 1'b0;
      end else begin
         rf_wr_o <= 1'b0;
         pg_wr_o <= 1'b0;
         load    <= 1'b0;
         if (!en_act_i) begin
            cnt    <= '0;
            dout_o <= 1'b0;
         end else begin
            if (rise_i && cnt < C_FRAME) begin
               sh  <= sh_nxt[HA_LEN-2:0];
               cnt <= cnt + 1'b1;
               if (cnt == C_HA - 1'b1) begin
                  hdr_o  <= hdr_t'(sh_nxt[HA_LEN-1:ADDR_W]);
                  addr_o <= sh_nxt[ADDR_W-1:0];
                  load   <= sh_nxt[HA_LEN-1];
               end
               if (cnt == C_FRAME - 1'b1) begin
                  wdata_o <= sh_nxt[DATA_W-1:0];
                  rf_wr_o <= !hdr_o.rd && hdr_o.reg_acc;
                  pg_wr_o <= !hdr_o.rd && !hdr_o.reg_acc;
               end
            end
            if (fall_i) begin
               if (hdr_o.rd && cnt >= C_HA && cnt < C_FRAME) begin
                  dout_o <= rd_sh[DATA_W-1];
                  rd_sh  <= rd_sh << 1;
               end else begin
                  dout_o <= 1'b0;
               end
            end
            if (load) rd_sh <= rd_src_i;
         end
      end
   end

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_o |=> !rf_wr_o); // R3
   AST_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr_o || pg_wr_o) |-> cnt == C_FRAME); // R4
   AST_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_wr_o && pg_wr_o)); // R5
   AST_RD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_wr_o || pg_wr_o) |-> !hdr_o.rd); // R10
   AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_act_i |=> !dout_o); // R9
   AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == C_FRAME |=> cnt == C_FRAME || cnt == '0); // R11
endmodule

// File: rtl/spi_bank_pages.sv
`timescale 1ns/1ps
module spi_bank_pages
   import spi_bank_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [PG_IDX_W-1:0] idx_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [DATA_W-1:0]   page_o
);
   logic [NUM_PG-1:0][DATA_W-1:0] pages;

   for (genvar g = 0; g < NUM_PG; g++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 pages[g] <= '0;
         else if (wr_i && idx_i == PG_IDX_W'(g))     pages[g] <= wdata_i;
      end
   end

   assign page_o = pages[idx_i];

   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(pages)); // R5
endmodule

// File: rtl/spi_bank_slave.sv
`timescale 1ns/1ps
module spi_bank_slave
   import spi_bank_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_en_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout,
   output logic              rf_bank,
   output logic              rf_chan,
   output logic [DATA_W-1:0] rf_page,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_wr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_param
      $error("spi_bank_slave: widths must be positive");
   end

   logic        rise, fall, en_act, din_s, pg_wr;
   hdr_t        hdr;
   logic [DATA_W-1:0] page_val, rd_src;

   spi_bank_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_i   (ser_clk),
      .en_n_i   (ser_en_n),
      .din_i    (ser_din),
      .rise_o   (rise),
      .fall_o   (fall),
      .en_act_o (en_act),
      .din_o    (din_s)
   );

   assign rd_src = hdr.reg_acc ? rf_rdata : page_val;

   spi_bank_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .rise_i   (rise),
      .fall_i   (fall),
      .en_act_i (en_act),
      .din_i    (din_s),
      .rd_src_i (rd_src),
      .hdr_o    (hdr),
      .addr_o   (rf_addr),
      .wdata_o  (rf_wdata),
      .rf_wr_o  (rf_wr),
      .pg_wr_o  (pg_wr),
      .dout_o   (ser_dout)
   );

   spi_bank_pages #(.DATA_W(DATA_W)) i_pages (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (pg_wr),
      .idx_i   ({hdr.digital, hdr.chan_b}),
      .wdata_i (rf_wdata),
      .page_o  (page_val)
   );

   assign rf_bank = hdr.digital;
   assign rf_chan = hdr.chan_b;
   assign rf_page = page_val;

   AST_WR_REGACC: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr |-> hdr.reg_acc); // R3
endmodule

// File: tb/test_spi_bank_slave.sv
`timescale 1ns/1ps
module test_spi_bank_slave;
   localparam int H = 100;

   logic clk = 1'b0, rst_n = 1'b0;
   logic en_n = 1'b1, sclk = 1'b0, din = 1'b0;
   logic dout, rf_bank, rf_chan, rf_wr;
   logic [7:0]  rf_page, rf_wdata, rf_rdata;
   logic [11:0] rf_addr;

   int n_chk = 0, n_fail = 0, wr_cnt = 0;
   logic [7:0]  cap_wdata, cap_page;
   logic [11:0] cap_addr;
   logic        cap_bank, cap_chan;
   logic        rdw = 1'b0, dout_bad = 1'b0;

   always #10 clk = ~clk;

   // register-file model driven by the bench
   assign rf_rdata = rf_addr[7:0] ^ {rf_bank, rf_chan, 6'h15} ^ rf_page;

   spi_bank_slave i_spi_bank_slave (
      .clk(clk), .rst_n(rst_n), .ser_en_n(en_n), .ser_clk(sclk),
      .ser_din(din), .ser_dout(dout), .rf_bank(rf_bank), .rf_chan(rf_chan),
      .rf_page(rf_page), .rf_addr(rf_addr), .rf_wr(rf_wr),
      .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
   );

   always @(negedge clk) begin
      if (rf_wr) begin
         wr_cnt++;
         cap_wdata = rf_wdata; cap_page = rf_page; cap_addr = rf_addr;
         cap_bank = rf_bank; cap_chan = rf_chan;
      end
      if (dout && !rdw) dout_bad = 1'b1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] mk(input logic rd, input logic bank, input logic rg,
                                      input logic ch, input logic [11:0] a, input logic [7:0] d);
      return {rd, bank, rg, ch, a, d};
   endfunction

   task automatic xfer(input logic [23:0] f, input int nbits, input bit late,
                       output logic [7:0] rd);
      rd = '0;
      rdw = f[23];
      en_n = 1'b0; #H;
      for (int i = 0; i < nbits; i++) begin
         din = (i < 24) ? f[23-i] : 1'b1;
         #H;
         if (i >= 16 && i < 24) rd[23-i] = dout;
         sclk = 1'b1;
         if (late && i == nbits - 1) en_n = 1'b1;
         #H;
         sclk = 1'b0;
      end
      #H; en_n = 1'b1; #(4*H);
      rdw = 1'b0;
   endtask

   logic [7:0] pv [4];
   logic [11:0] addrs [4];

   initial begin
      logic [7:0] r;
      int base;
      addrs[0] = 12'h000; addrs[1] = 12'hA5C; addrs[2] = 12'hFFF; addrs[3] = 12'h3F0;
      for (int k = 0; k < 4; k++) pv[k] = 8'h3C + 8'(37 * k);
      #100 rst_n = 1'b1;
      #40;
      check("R6 reset page", rf_page, 0);
      check("R3 reset strobe", rf_wr, 0);
      check("R9 reset dout", dout, 0);

      // R1: clock pulses while deselected
      din = 1'b1;
      for (int i = 0; i < 5; i++) begin sclk = 1'b1; #H; sclk = 1'b0; #H; end

      // R5: page writes for every bank/channel pair
      for (int k = 0; k < 4; k++) begin
         base = wr_cnt;
         xfer(mk(1'b0, k[1], 1'b0, k[0], 12'h000, pv[k]), 24, 1'b0, r);
         check("R5 page write no strobe", wr_cnt, base);
      end

      // R2 R3 R6: register writes
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < 3; j++) begin
            base = wr_cnt;
            xfer(mk(1'b0, k[1], 1'b1, k[0], addrs[j], addrs[j][7:0] ^ 8'h5A), 24, 1'b0, r);
            check("R3 one strobe", wr_cnt, base + 1);
            check("R2 addr", cap_addr, addrs[j]);
            check("R2 wdata", cap_wdata, addrs[j][7:0] ^ 8'h5A);
            check("R2 bank/chan", {cap_bank, cap_chan}, k[1:0]);
            check("R6 page", cap_page, pv[k]);
         end
      end

      // R7 R10: register reads
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < 4; j++) begin
            base = wr_cnt;
            xfer(mk(1'b1, k[1], 1'b1, k[0], addrs[j], 8'h00), 24, 1'b0, r);
            check("R7 readback", r, addrs[j][7:0] ^ {k[1], k[0], 6'h15} ^ pv[k]);
            check("R10 read no strobe", wr_cnt, base);
         end
      end

      // R8: page reads
      for (int k = 0; k < 4; k++) begin
         xfer(mk(1'b1, k[1], 1'b0, k[0], 12'h000, 8'h00), 24, 1'b0, r);
         check("R8 page readback", r, pv[k]);
      end

      // R4: truncated frames
      base = wr_cnt;
      xfer(mk(1'b0, 1'b1, 1'b1, 1'b1, 12'h123, 8'hEE), 23, 1'b0, r);
      xfer(mk(1'b0, 1'b1, 1'b1, 1'b1, 12'h123, 8'hEE), 10, 1'b0, r);
      check("R4 partial no strobe", wr_cnt, base);
      xfer(mk(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 8'h99), 23, 1'b0, r);
      xfer(mk(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 8'h99), 10, 1'b0, r);
      xfer(mk(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 8'h00), 24, 1'b0, r);
      check("R4 partial page unchanged", r, pv[2]);

      // R4: deselect together with the last rising edge
      base = wr_cnt;
      xfer(mk(1'b0, 1'b0, 1'b1, 1'b0, 12'h777, 8'h42), 24, 1'b1, r);
      check("R4 late deselect no strobe", wr_cnt, base);
      xfer(mk(1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 8'hC3), 24, 1'b1, r);
      xfer(mk(1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 8'h00), 24, 1'b0, r);
      check("R4 late deselect page unchanged", r, pv[1]);

      // R11: overlong frame
      base = wr_cnt;
      xfer(mk(1'b0, 1'b0, 1'b1, 1'b1, 12'h456, 8'h77), 30, 1'b0, r);
      check("R11 single strobe", wr_cnt, base + 1);
      check("R11 data kept", cap_wdata, 8'h77);
      check("R1 addr after idle pulses", cap_addr, 12'h456);

      // R10: read frame leaves pages untouched
      xfer(mk(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 8'hFF), 24, 1'b0, r);
      check("R10 page after read", r, pv[0]);

      check("R9 dout quiet outside reads", dout_bad, 0);
      check("R9 dout idle", dout, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #3_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule